// File: doc/BRIEF.md
# Hybrid Set/Fully-Associative TLB Lookup

This block holds translation entries in two structures and answers one question per request: does a virtual address, seen under the current address-space ID, hit a stored entry, and if so which one. The first structure is a set-associative store. Every entry in it uses one page size, which software sets for the whole store. The second is a small fully associative store in which each entry carries its own page size. Each entry maps an even/odd pair of adjacent pages, so the compared virtual page number is the address shifted right by page size plus one.

A lookup takes a fixed two cycles and ends with a single-cycle done pulse. A fill port places a new entry. If its page size equals the global size, it goes to a pseudo-random way of the set its address selects. Otherwise it goes to a pseudo-random fully associative slot. The chosen index appears on an output in the same cycle as the fill. An invalidate port clears the existence bit of entries, selected by ASID, by global bit or by page.

Top module: `tlb_hybrid_lookup`

## Requirements
- R1: While reset is held and after its release, no entry exists: `lk_done_o` is low and every lookup misses.
- R2: A request on `lk_valid_i` gives `lk_done_o` high for exactly one cycle, two clock edges later. `lk_hit_o` and `lk_index_o` are meaningful only with done. On a miss the index is 0.
- R3: An entry hits when its existence bit is set, when its global bit is set or its stored ASID equals `asid_i`, and when stored address bits [VA_W-1:PS+1] equal those of the lookup address. A set-associative entry reports index way*256 + set. The set is bits [7:0] of (address >> (PS+1)), where PS is `page_size_i`.
- R4: Address bits below PS+1 are ignored. Both pages of the even/odd pair (bit PS differs) hit the same entry.
- R5: The set-associative store takes priority. A fully associative entry is reported only when no set-associative entry hits. Such an entry reports index 2048 + slot.
- R6: A fully associative entry compares with its own stored page size, not with `page_size_i`.
- R7: A fill whose `fill_ps_i` equals `page_size_i` lands at an index below 2048, with index mod 256 equal to the set of its address. Any other size lands at an index from 2048 to 2111. The entry stores `asid_i`, `fill_global_i` and the address bits. `fill_index_o` is valid in the cycle of `fill_valid_i`.
- R8: Invalidate opcode 3 clears entries that are non-global and whose ASID equals `inv_asid_i`.
- R9: Opcode 0 clears every entry. Opcode 1 clears entries with global bit 0. Opcode 2 clears entries with global bit 1.
- R10: Opcode 4 clears entries that are non-global, whose ASID matches `inv_asid_i` and whose page pair holds `inv_va_i`. Fully associative entries use their own page size for this test.
- R11: Opcode 5 clears entries whose page pair holds `inv_va_i` and that are global or match on ASID.
- R12: A non-global entry misses when `asid_i` differs from its stored ASID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| page_size_i | input | 6 | Global page size (log2 bytes) of the set-associative store |
| asid_i | input | 10 | Current address-space ID for lookup and fill |
| lk_valid_i | input | 1 | Lookup request |
| lk_va_i | input | 48 | Lookup virtual address |
| lk_done_o | output | 1 | Lookup result strobe |
| lk_hit_o | output | 1 | Lookup hit |
| lk_index_o | output | 12 | Index of the hit entry |
| fill_valid_i | input | 1 | Fill request |
| fill_va_i | input | 48 | Fill virtual address |
| fill_ps_i | input | 6 | Page size of the entry being filled |
| fill_global_i | input | 1 | Global bit of the entry being filled |
| fill_index_o | output | 12 | Index the fill writes |
| inv_valid_i | input | 1 | Invalidate request |
| inv_op_i | input | 3 | Invalidate opcode (0 to 5) |
| inv_asid_i | input | 10 | ASID operand for invalidation |
| inv_va_i | input | 48 | Address operand for page invalidation |

## Verification
The bench probes the odd page of a pair and offsets below the pair size. A design that shifted by PS instead of PS+1 would miss these. It also flips the bit just above a large fully associative page. A design that compared that entry with the global size would hit or miss wrongly there. The same address is placed in both stores, and the entry that shadowed it is then removed. This exposes a reversed priority or a fully associative search that never runs. Each invalidate opcode is tried against global and non-global entries with matching and non-matching ASIDs. A swapped global test or a page compare that is too loose would leave the wrong survivors.

// File: rtl/tlb_hyb_pkg.sv
package tlb_hyb_pkg;
  typedef enum logic [2:0] {
    INV_ALL         = 3'd0,
    INV_G0          = 3'd1,
    INV_G1          = 3'd2,
    INV_ASID        = 3'd3,
    INV_PAGE_ASID   = 3'd4,
    INV_PAGE_ASID_G = 3'd5
  } inv_op_e;
endpackage

// File: rtl/tlb_vpn_cmp.sv
module tlb_vpn_cmp #(
  parameter int unsigned VPPN_W   = 35,
  parameter int unsigned PS_W     = 6,
  parameter int unsigned VPPN_LSB = 13
) (
  input  logic [VPPN_W-1:0] a_i,
  input  logic [VPPN_W-1:0] b_i,
  input  logic [PS_W-1:0]   ps_i,
  output logic              eq_o
);
  logic [VPPN_W-1:0] mask;

  // keep only bits at or above PS+1 (pair granularity)
  always_comb begin
    for (int i = 0; i < VPPN_W; i++) begin
      mask[i] = (i + int'(VPPN_LSB)) >= (int'(ps_i) + 1);
    end
  end

  assign eq_o = ((a_i ^ b_i) & mask) == '0;
endmodule

// File: rtl/tlb_lfsr.sv
module tlb_lfsr #(
  parameter int unsigned W     = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter int unsigned OUT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [OUT_W-1:0] rnd_o
);
  logic [W-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= {1'b0, state_q[W-1:1]} ^ (state_q[0] ? TAPS : '0);
  end

  assign rnd_o = state_q[OUT_W-1:0];
endmodule

// File: rtl/tlb_sa_array.sv
module tlb_sa_array import tlb_hyb_pkg::*; #(
  parameter int unsigned VA_W     = 48,
  parameter int unsigned ASID_W   = 10,
  parameter int unsigned PS_W     = 6,
  parameter int unsigned NWAY     = 8,
  parameter int unsigned NSET     = 256,
  parameter int unsigned VPPN_LSB = 13,
  localparam int unsigned SET_W   = $clog2(NSET),
  localparam int unsigned WAY_W   = $clog2(NWAY),
  localparam int unsigned VPPN_W  = VA_W - VPPN_LSB
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [PS_W-1:0]        ps_i,
  input  logic [VA_W-1:0]        lk_va_i,
  input  logic [ASID_W-1:0]      lk_asid_i,
  input  logic [PS_W-1:0]        lk_ps_i,
  output logic                   lk_hit_o,
  output logic [WAY_W+SET_W-1:0] lk_idx_o,
  input  logic                   wr_en_i,
  input  logic [WAY_W-1:0]       wr_way_i,
  input  logic [SET_W-1:0]       wr_set_i,
  input  logic [VPPN_W-1:0]      wr_vppn_i,
  input  logic [ASID_W-1:0]      wr_asid_i,
  input  logic                   wr_g_i,
  input  logic                   inv_en_i,
  input  inv_op_e                inv_op_i,
  input  logic [ASID_W-1:0]      inv_asid_i,
  input  logic [VA_W-1:0]        inv_va_i
);
  logic [SET_W-1:0] lk_set, inv_set;
  logic [NWAY-1:0]  hit_vec;
  logic [WAY_W-1:0] hit_way;

  assign lk_set  = SET_W'(lk_va_i  >> ({1'b0, lk_ps_i} + 7'd1));
  assign inv_set = SET_W'(inv_va_i >> ({1'b0, ps_i}    + 7'd1));

  for (genvar w = 0; w < NWAY; w++) begin : g_way
    logic [NSET-1:0]   e_q, g_q, clr;
    logic [ASID_W-1:0] asid_q [NSET];
    logic [VPPN_W-1:0] vppn_q [NSET];
    logic              lk_eq, inv_eq, wr_sel;

    tlb_vpn_cmp #(.VPPN_W(VPPN_W), .PS_W(PS_W), .VPPN_LSB(VPPN_LSB)) u_lk_cmp (
      .a_i(vppn_q[lk_set]), .b_i(lk_va_i[VA_W-1:VPPN_LSB]), .ps_i(lk_ps_i), .eq_o(lk_eq));
    tlb_vpn_cmp #(.VPPN_W(VPPN_W), .PS_W(PS_W), .VPPN_LSB(VPPN_LSB)) u_inv_cmp (
      .a_i(vppn_q[inv_set]), .b_i(inv_va_i[VA_W-1:VPPN_LSB]), .ps_i(ps_i), .eq_o(inv_eq));

    assign hit_vec[w] = e_q[lk_set] && (g_q[lk_set] || asid_q[lk_set] == lk_asid_i) && lk_eq;
    assign wr_sel     = wr_en_i && (wr_way_i == WAY_W'(w));

    // page ops touch only the set the page maps to
    always_comb begin
      for (int s = 0; s < NSET; s++) begin
        unique case (inv_op_i)
          INV_ALL:         clr[s] = 1'b1;
          INV_G0:          clr[s] = !g_q[s];
          INV_G1:          clr[s] = g_q[s];
          INV_ASID:        clr[s] = !g_q[s] && (asid_q[s] == inv_asid_i);
          INV_PAGE_ASID:   clr[s] = (SET_W'(s) == inv_set) && inv_eq &&
                                    !g_q[s] && (asid_q[s] == inv_asid_i);
          INV_PAGE_ASID_G: clr[s] = (SET_W'(s) == inv_set) && inv_eq &&
                                    (g_q[s] || (asid_q[s] == inv_asid_i));
          default:         clr[s] = 1'b0;
        endcase
        clr[s] = clr[s] && inv_en_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        e_q <= '0;
      end else begin
        e_q <= e_q & ~clr;
        if (wr_sel) e_q[wr_set_i] <= 1'b1;
      end
    end

    always_ff @(posedge clk_i) begin
      if (wr_sel) begin
        g_q[wr_set_i]    <= wr_g_i;
        asid_q[wr_set_i] <= wr_asid_i;
        vppn_q[wr_set_i] <= wr_vppn_i;
      end
    end
  end

  always_comb begin
    hit_way = '0;
    for (int w = NWAY - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

  assign lk_hit_o = |hit_vec;
  assign lk_idx_o = {hit_way, lk_set};
endmodule

// File: rtl/tlb_fa_array.sv
module tlb_fa_array import tlb_hyb_pkg::*; #(
  parameter int unsigned VA_W     = 48,
  parameter int unsigned ASID_W   = 10,
  parameter int unsigned PS_W     = 6,
  parameter int unsigned NFA      = 64,
  parameter int unsigned VPPN_LSB = 13,
  localparam int unsigned FA_W    = $clog2(NFA),
  localparam int unsigned VPPN_W  = VA_W - VPPN_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VA_W-1:0]   lk_va_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  output logic              lk_hit_o,
  output logic [FA_W-1:0]   lk_idx_o,
  input  logic              wr_en_i,
  input  logic [FA_W-1:0]   wr_sel_i,
  input  logic [VPPN_W-1:0] wr_vppn_i,
  input  logic [PS_W-1:0]   wr_ps_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic              wr_g_i,
  input  logic              inv_en_i,
  input  inv_op_e           inv_op_i,
  input  logic [ASID_W-1:0] inv_asid_i,
  input  logic [VA_W-1:0]   inv_va_i
);
  logic [NFA-1:0] hit_vec;

  for (genvar i = 0; i < NFA; i++) begin : g_ent
    logic              e_q, g_q, clr, lk_eq, inv_eq, asid_eq, wr_here;
    logic [ASID_W-1:0] asid_q;
    logic [VPPN_W-1:0] vppn_q;
    logic [PS_W-1:0]   ps_q;

    tlb_vpn_cmp #(.VPPN_W(VPPN_W), .PS_W(PS_W), .VPPN_LSB(VPPN_LSB)) u_lk_cmp (
      .a_i(vppn_q), .b_i(lk_va_i[VA_W-1:VPPN_LSB]), .ps_i(ps_q), .eq_o(lk_eq));
    tlb_vpn_cmp #(.VPPN_W(VPPN_W), .PS_W(PS_W), .VPPN_LSB(VPPN_LSB)) u_inv_cmp (
      .a_i(vppn_q), .b_i(inv_va_i[VA_W-1:VPPN_LSB]), .ps_i(ps_q), .eq_o(inv_eq));

    assign hit_vec[i] = e_q && (g_q || asid_q == lk_asid_i) && lk_eq;
    assign asid_eq    = asid_q == inv_asid_i;
    assign wr_here    = wr_en_i && (wr_sel_i == FA_W'(i));

    always_comb begin
      unique case (inv_op_i)
        INV_ALL:         clr = 1'b1;
        INV_G0:          clr = !g_q;
        INV_G1:          clr = g_q;
        INV_ASID:        clr = !g_q && asid_eq;
        INV_PAGE_ASID:   clr = inv_eq && !g_q && asid_eq;
        INV_PAGE_ASID_G: clr = inv_eq && (g_q || asid_eq);
        default:         clr = 1'b0;
      endcase
      clr = clr && inv_en_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      e_q <= 1'b0;
      else if (wr_here) e_q <= 1'b1;
      else if (clr)     e_q <= 1'b0;
    end

    always_ff @(posedge clk_i) begin
      if (wr_here) begin
        g_q    <= wr_g_i;
        asid_q <= wr_asid_i;
        vppn_q <= wr_vppn_i;
        ps_q   <= wr_ps_i;
      end
    end
  end

  // lowest slot wins when several overlap
  always_comb begin
    lk_idx_o = '0;
    for (int i = NFA - 1; i >= 0; i--) begin
      if (hit_vec[i]) lk_idx_o = FA_W'(i);
    end
  end

  assign lk_hit_o = |hit_vec;
endmodule

// File: rtl/tlb_hybrid_lookup.sv
module tlb_hybrid_lookup import tlb_hyb_pkg::*; #(
  parameter int unsigned VA_W     = 48,
  parameter int unsigned ASID_W   = 10,
  parameter int unsigned PS_W     = 6,
  parameter int unsigned NWAY     = 8,
  parameter int unsigned NSET     = 256,
  parameter int unsigned NFA      = 64,
  parameter int unsigned VPPN_LSB = 13,
  localparam int unsigned SA_N    = NWAY * NSET,
  localparam int unsigned IDX_W   = $clog2(SA_N + NFA),
  localparam int unsigned SET_W   = $clog2(NSET),
  localparam int unsigned WAY_W   = $clog2(NWAY),
  localparam int unsigned FA_W    = $clog2(NFA),
  localparam int unsigned RND_W   = (FA_W > WAY_W) ? FA_W : WAY_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PS_W-1:0]   page_size_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              lk_valid_i,
  input  logic [VA_W-1:0]   lk_va_i,
  output logic              lk_done_o,
  output logic              lk_hit_o,
  output logic [IDX_W-1:0]  lk_index_o,
  input  logic              fill_valid_i,
  input  logic [VA_W-1:0]   fill_va_i,
  input  logic [PS_W-1:0]   fill_ps_i,
  input  logic              fill_global_i,
  output logic [IDX_W-1:0]  fill_index_o,
  input  logic              inv_valid_i,
  input  logic [2:0]        inv_op_i,
  input  logic [ASID_W-1:0] inv_asid_i,
  input  logic [VA_W-1:0]   inv_va_i
);
  logic [RND_W-1:0]       rnd;
  logic                   s1_vld_q, s2_vld_q, s2_hit_q;
  logic [VA_W-1:0]        s1_va_q;
  logic [ASID_W-1:0]      s1_asid_q;
  logic [PS_W-1:0]        s1_ps_q;
  logic [IDX_W-1:0]       s2_idx_q, s1_idx;
  logic                   sa_hit, fa_hit, to_sa;
  logic [WAY_W+SET_W-1:0] sa_idx;
  logic [FA_W-1:0]        fa_idx;
  logic [SET_W-1:0]       fill_set;
  inv_op_e                inv_op;

  assign inv_op   = inv_op_e'(inv_op_i);
  assign to_sa    = fill_ps_i == page_size_i;
  assign fill_set = SET_W'(fill_va_i >> ({1'b0, page_size_i} + 7'd1));

  tlb_lfsr #(.OUT_W(RND_W)) u_lfsr (.clk_i(clk_i), .rst_ni(rst_ni), .rnd_o(rnd));

  tlb_sa_array #(
    .VA_W(VA_W), .ASID_W(ASID_W), .PS_W(PS_W),
    .NWAY(NWAY), .NSET(NSET), .VPPN_LSB(VPPN_LSB)
  ) u_sa (
    .clk_i, .rst_ni,
    .ps_i      (page_size_i),
    .lk_va_i   (s1_va_q),
    .lk_asid_i (s1_asid_q),
    .lk_ps_i   (s1_ps_q),
    .lk_hit_o  (sa_hit),
    .lk_idx_o  (sa_idx),
    .wr_en_i   (fill_valid_i && to_sa),
    .wr_way_i  (rnd[WAY_W-1:0]),
    .wr_set_i  (fill_set),
    .wr_vppn_i (fill_va_i[VA_W-1:VPPN_LSB]),
    .wr_asid_i (asid_i),
    .wr_g_i    (fill_global_i),
    .inv_en_i  (inv_valid_i),
    .inv_op_i  (inv_op),
    .inv_asid_i(inv_asid_i),
    .inv_va_i  (inv_va_i)
  );

  tlb_fa_array #(
    .VA_W(VA_W), .ASID_W(ASID_W), .PS_W(PS_W), .NFA(NFA), .VPPN_LSB(VPPN_LSB)
  ) u_fa (
    .clk_i, .rst_ni,
    .lk_va_i   (s1_va_q),
    .lk_asid_i (s1_asid_q),
    .lk_hit_o  (fa_hit),
    .lk_idx_o  (fa_idx),
    .wr_en_i   (fill_valid_i && !to_sa),
    .wr_sel_i  (rnd[FA_W-1:0]),
    .wr_vppn_i (fill_va_i[VA_W-1:VPPN_LSB]),
    .wr_ps_i   (fill_ps_i),
    .wr_asid_i (asid_i),
    .wr_g_i    (fill_global_i),
    .inv_en_i  (inv_valid_i),
    .inv_op_i  (inv_op),
    .inv_asid_i(inv_asid_i),
    .inv_va_i  (inv_va_i)
  );

  // set-associative store shadows the associative one
  always_comb begin
    if (sa_hit)      s1_idx = IDX_W'(sa_idx);
    else if (fa_hit) s1_idx = IDX_W'(SA_N) + IDX_W'(fa_idx);
    else             s1_idx = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q <= 1'b0;
      s2_vld_q <= 1'b0;
      s2_hit_q <= 1'b0;
      s2_idx_q <= '0;
    end else begin
      s1_vld_q <= lk_valid_i;
      s2_vld_q <= s1_vld_q;
      s2_hit_q <= s1_vld_q && (sa_hit || fa_hit);
      s2_idx_q <= s1_vld_q ? s1_idx : '0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (lk_valid_i) begin
      s1_va_q   <= lk_va_i;
      s1_asid_q <= asid_i;
      s1_ps_q   <= page_size_i;
    end
  end

  assign lk_done_o    = s2_vld_q;
  assign lk_hit_o     = s2_hit_q;
  assign lk_index_o   = s2_idx_q;
  assign fill_index_o = to_sa ? (IDX_W'(rnd[WAY_W-1:0]) * IDX_W'(NSET) + IDX_W'(fill_set))
                              : (IDX_W'(SA_N) + IDX_W'(rnd[FA_W-1:0]));
endmodule

// File: rtl/tlb_hybrid_lookup_chk.sv
module tlb_hybrid_lookup_chk #(
  parameter int unsigned PS_W  = 6,
  parameter int unsigned NWAY  = 8,
  parameter int unsigned NSET  = 256,
  parameter int unsigned NFA   = 64,
  localparam int unsigned SA_N  = NWAY * NSET,
  localparam int unsigned IDX_W = $clog2(SA_N + NFA)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lk_valid_i,
  input logic             lk_done_o,
  input logic             lk_hit_o,
  input logic [IDX_W-1:0] lk_index_o,
  input logic             fill_valid_i,
  input logic [PS_W-1:0]  fill_ps_i,
  input logic [PS_W-1:0]  page_size_i,
  input logic [IDX_W-1:0] fill_index_o
);
  p_done_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> ##1 lk_done_o);
  p_no_spurious_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> ##1 !lk_done_o);
  p_hit_with_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> lk_done_o);
  p_miss_index_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_done_o && !lk_hit_o) |-> (lk_index_o == '0));
  p_fill_sa_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && fill_ps_i == page_size_i) |-> (fill_index_o < IDX_W'(SA_N)));
  p_fill_fa_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && fill_ps_i != page_size_i) |->
      (fill_index_o >= IDX_W'(SA_N) && fill_index_o < IDX_W'(SA_N + NFA)));
endmodule

bind tlb_hybrid_lookup tlb_hybrid_lookup_chk #(
  .PS_W(PS_W), .NWAY(NWAY), .NSET(NSET), .NFA(NFA)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lk_valid_i(lk_valid_i), .lk_done_o(lk_done_o),
  .lk_hit_o(lk_hit_o), .lk_index_o(lk_index_o), .fill_valid_i(fill_valid_i),
  .fill_ps_i(fill_ps_i), .page_size_i(page_size_i), .fill_index_o(fill_index_o)
);

// File: tb/tlb_hybrid_lookup_bench.sv
module tlb_hybrid_lookup_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  page_size_i = 6'd12;
  logic [9:0]  asid_i = '0;
  logic        lk_valid_i = 1'b0;
  logic [47:0] lk_va_i = '0;
  logic        lk_done_o, lk_hit_o;
  logic [11:0] lk_index_o, fill_index_o;
  logic        fill_valid_i = 1'b0;
  logic [47:0] fill_va_i = '0;
  logic [5:0]  fill_ps_i = '0;
  logic        fill_global_i = 1'b0;
  logic        inv_valid_i = 1'b0;
  logic [2:0]  inv_op_i = '0;
  logic [9:0]  inv_asid_i = '0;
  logic [47:0] inv_va_i = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  tlb_hybrid_lookup u_tlb_hybrid_lookup (.*);

  localparam logic [47:0] VX = 48'h0000_1000_2000;
  localparam logic [47:0] VY = 48'h0000_1000_4000;
  localparam logic [47:0] VZ = 48'h0000_1000_6000;
  localparam logic [47:0] VV = 48'h0000_1000_8000;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [47:0] va, input logic [9:0] asid,
                        output bit hit, output int idx);
    @(negedge clk_i);
    asid_i = asid; lk_valid_i = 1'b1; lk_va_i = va;
    @(negedge clk_i);
    lk_valid_i = 1'b0;
    chk(lk_done_o == 1'b0, "R2 done early", lk_done_o, 0);
    @(negedge clk_i);
    chk(lk_done_o == 1'b1, "R2 done at two edges", lk_done_o, 1);
    hit = lk_hit_o; idx = int'(lk_index_o);
    @(negedge clk_i);
    chk(lk_done_o == 1'b0, "R2 done one cycle", lk_done_o, 0);
  endtask

  task automatic expect_hit(input logic [47:0] va, input logic [9:0] asid,
                            input int exp_idx, input string req);
    bit h; int i;
    lookup(va, asid, h, i);
    chk(h && i == exp_idx, req, h ? i : -1, exp_idx);
  endtask

  task automatic expect_miss(input logic [47:0] va, input logic [9:0] asid, input string req);
    bit h; int i;
    lookup(va, asid, h, i);
    chk(!h, req, h, 0);
    chk(i == 0, "R2 miss index zero", i, 0);
  endtask

  task automatic fill(input logic [47:0] va, input logic [5:0] ps, input bit g,
                      input logic [9:0] asid, output int idx);
    @(negedge clk_i);
    asid_i = asid; fill_valid_i = 1'b1; fill_va_i = va; fill_ps_i = ps; fill_global_i = g;
    #1 idx = int'(fill_index_o);
    @(negedge clk_i);
    fill_valid_i = 1'b0;
  endtask

  task automatic inval(input logic [2:0] op, input logic [9:0] asid, input logic [47:0] va);
    @(negedge clk_i);
    inv_valid_i = 1'b1; inv_op_i = op; inv_asid_i = asid; inv_va_i = va;
    @(negedge clk_i);
    inv_valid_i = 1'b0;
  endtask

  task automatic t_reset;
    expect_miss(48'h1234_5678_0000, 10'd0, "R1 empty after reset");
  endtask

  task automatic t_sa_basic;
    int a, b;
    logic [47:0] va = 48'h0000_1234_5000;
    inval(3'd0, 0, 0);
    fill(va, 6'd12, 1'b0, 10'd7, a);
    chk(a < 2048 && (a % 256) == int'((va >> 13) & 48'hFF), "R7 set-assoc placement",
        a, (va >> 13) & 48'hFF);
    expect_hit(va, 10'd7, a, "R3 exact hit");
    expect_hit(va ^ 48'h1000, 10'd7, a, "R4 odd page of pair");
    expect_hit(va | 48'h0FFF, 10'd7, a, "R4 offset bits ignored");
    expect_miss(va ^ 48'h2000, 10'd7, "R3 other set");
    expect_miss(va ^ (48'h1 << 30), 10'd7, "R3 tag differs");
    expect_miss(va, 10'd8, "R12 asid mismatch");
    fill(VV, 6'd12, 1'b1, 10'd7, b);
    expect_hit(VV, 10'd9, b, "R3 global ignores asid");
  endtask

  task automatic t_fa;
    int f;
    logic [47:0] w = 48'h0000_2222_8000;
    inval(3'd0, 0, 0);
    fill(w, 6'd14, 1'b0, 10'd2, f);
    chk(f >= 2048 && f < 2112, "R7 assoc placement", f, 2048);
    expect_hit(w, 10'd2, 2048 + (f - 2048), "R5 assoc hit on set miss");
    expect_hit(w + 48'h4000, 10'd2, f, "R6 odd page at own size");
    expect_hit(w + 48'h1234, 10'd2, f, "R6 inside large pair");
    expect_miss(w ^ 48'h8000, 10'd2, "R6 bit above own pair");
  endtask

  task automatic t_priority;
    int s, f;
    logic [47:0] p = 48'h0003_0000_A000;
    inval(3'd0, 0, 0);
    fill(p, 6'd12, 1'b0, 10'd3, s);
    fill(p, 6'd14, 1'b1, 10'd3, f);
    expect_hit(p, 10'd3, s, "R5 set-assoc wins");
    inval(3'd3, 10'd3, 0);
    expect_hit(p, 10'd3, f, "R5 assoc after set-assoc cleared");
  endtask

  task automatic t_inv_asid;
    int a, b, c;
    inval(3'd0, 0, 0);
    fill(VX, 6'd12, 1'b0, 10'd3, a);
    fill(VY, 6'd12, 1'b0, 10'd4, b);
    fill(VZ, 6'd12, 1'b1, 10'd3, c);
    inval(3'd3, 10'd3, 0);
    expect_miss(VX, 10'd3, "R8 matching asid cleared");
    expect_hit(VY, 10'd4, b, "R8 other asid kept");
    expect_hit(VZ, 10'd3, c, "R8 global kept");
  endtask

  task automatic t_inv_global;
    int a, b;
    inval(3'd0, 0, 0);
    fill(VX, 6'd12, 1'b0, 10'd1, a);
    fill(VY, 6'd12, 1'b1, 10'd1, b);
    inval(3'd1, 0, 0);
    expect_miss(VX, 10'd1, "R9 op1 clears non-global");
    expect_hit(VY, 10'd1, b, "R9 op1 keeps global");
    fill(VX, 6'd12, 1'b0, 10'd1, a);
    inval(3'd2, 0, 0);
    expect_miss(VY, 10'd1, "R9 op2 clears global");
    expect_hit(VX, 10'd1, a, "R9 op2 keeps non-global");
    inval(3'd0, 0, 0);
    expect_miss(VX, 10'd1, "R9 op0 clears all");
  endtask

  task automatic t_inv_page;
    int a, b, c, d;
    logic [47:0] w2 = 48'h0000_5555_0000;
    inval(3'd0, 0, 0);
    fill(VX, 6'd12, 1'b0, 10'd3, a);
    fill(VY, 6'd12, 1'b0, 10'd3, b);
    fill(VZ, 6'd12, 1'b1, 10'd3, c);
    fill(w2, 6'd14, 1'b0, 10'd3, d);
    inval(3'd4, 10'd3, VX);
    expect_miss(VX, 10'd3, "R10 page+asid cleared");
    expect_hit(VY, 10'd3, b, "R10 other page kept");
    inval(3'd4, 10'd3, VZ);
    expect_hit(VZ, 10'd3, c, "R10 global kept");
    inval(3'd4, 10'd3, w2 + 48'h5000);
    expect_miss(w2, 10'd3, "R10 assoc entry by own size");
  endtask

  task automatic t_inv_page_g;
    int c, e;
    inval(3'd0, 0, 0);
    fill(VZ, 6'd12, 1'b1, 10'd3, c);
    fill(VV, 6'd12, 1'b0, 10'd5, e);
    inval(3'd5, 10'd9, VZ);
    expect_miss(VZ, 10'd3, "R11 global page cleared");
    inval(3'd5, 10'd6, VV);
    expect_hit(VV, 10'd5, e, "R11 asid mismatch kept");
    inval(3'd5, 10'd5, VV);
    expect_miss(VV, 10'd5, "R11 asid match cleared");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(lk_done_o == 1'b0, "R1 no done in reset", lk_done_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_sa_basic();
    t_fa();
    t_priority();
    t_inv_asid();
    t_inv_global();
    t_inv_page();
    t_inv_page_g();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule